// File: doc/BRIEF.md
# SD Card Multi-Block Data Write Engine

This block drives the data lines of an SD card while a multiple-block write is in progress. Software first sends the block-count and multiple-write commands on the command line. It then pulses `start` with the number of blocks and the bus width. From that point the engine works alone. It fetches bytes from a buffer through a fixed-latency read port and frames each 512-byte block with a start bit, the payload, a per-line CRC16 and an end bit. It then releases the lines and listens on DAT0 for the card's CRC status token and busy period.

Blocks follow one another with no software involvement until the programmed count is used up. The engine drives either one data line or four. The data phase shrinks by four in the wide mode, while the card's busy time stays what the card makes it. The busy wait has no time limit, because a card can stay busy for around a millisecond. A rejected block stops the transfer and raises an error flag. A completed transfer raises a done flag.

Top module: `sd_mbw_engine`

## Requirements
- R1: A `start` pulse with a non-zero `blk_count` launches a transfer. A `start` pulse with `blk_count` equal to zero is ignored: no line is driven, no byte is requested, and `done` and `err` keep their values.
- R2: Every block begins with one cycle in which all active lines are low. In narrow mode (`wide`=0) only bit 0 of `dat_oe` is set. In wide mode (`wide`=1) all four bits are set. A 512-byte payload follows, MSB first. In narrow mode each byte goes out as eight bits on line 0. In wide mode each byte goes out as two nibbles, with byte bit 7..4 on lines 3..0 first and bit 3..0 after.
- R3: Within a block the lines stay driven without a gap: 1 + 4096/L payload cycles + 16 + 1 cycles, where L is 1 or 4 active lines.
- R4: Each active line carries its own CRC16 after the payload. The CRC uses polynomial 0x1021, starts from zero, covers that line's payload bits, and is sent MSB first.
- R5: An end cycle with all active lines high closes each block. All lines are released (`dat_oe`=0) in the next cycle.
- R6: Bytes are requested with `rd_req` and consecutive `rd_addr` values. The address starts at 0 for each transfer and runs across block boundaries. `rd_data` is taken in the cycle after the request.
- R7: After each block the engine waits for a low start bit on `dat0_i` and samples the next three bits as the status token. The token 0-1-0 accepts the block. Any other token sets `err`, ends the transfer and drives no further block.
- R8: After an accepted token and its end bit, no new block starts while `dat0_i` is low, however long that lasts.
- R9: Blocks repeat until `blk_count` blocks have been accepted. `done` rises in the cycle after `dat0_i` is seen high at the end of the last busy period. `done` and `err` are never set together.
- R10: `done` and `err` clear when a new transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a transfer |
| wide | input | 1 | 1 selects four data lines, 0 selects line 0 only |
| blk_count | input | CNT_W (16) | Number of blocks to write |
| rd_req | output | 1 | Byte request to the buffer |
| rd_addr | output | ADDR_W (24) | Byte address of the request |
| rd_data | input | 8 | Byte returned one cycle after the request |
| dat_o | output | 4 | Values driven onto the data lines |
| dat_oe | output | 4 | Per-line drive enable |
| dat0_i | input | 1 | Level of DAT0 as seen from the card side |
| done | output | 1 | Transfer finished, every block accepted |
| err | output | 1 | Transfer aborted on a rejected token |

## Verification
The hardest situations to reach are a rejected token arriving in the middle of a multi-block transfer and a busy period long enough to expose any hidden timeout. The bench includes a behavioural card that replies after every block with a chosen token and a chosen busy length. It sweeps all eight token values on single-block transfers and injects a bad token on the second block of a pair. It also holds DAT0 low for twenty thousand cycles between two blocks, checking at every one of those cycles that the lines stay released.

// File: rtl/sd_mbw_pkg.sv
package sd_mbw_pkg;

   localparam int unsigned LANES = 4;
   localparam logic [15:0] CRC16_POLY = 16'h1021;

   typedef enum logic [2:0] {
      S_IDLE, S_PREP, S_START, S_DATA, S_CRC, S_ENDB, S_RESP
   } wr_state_t;

   typedef enum logic [2:0] {
      R_IDLE, R_WAITSB, R_TOK, R_TEND, R_BUSY
   } rsp_state_t;

   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
   endfunction

endpackage

// File: rtl/sd_mbw_crc_lane.sv
module sd_mbw_crc_lane
   import sd_mbw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic upd,
   input  logic bit_i,
   input  logic shift,
   output logic msb
);
   logic [15:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= 16'h0000;
      else if (clr)   crc_q <= 16'h0000;
      else if (upd)   crc_q <= crc16_step(crc_q, bit_i);
      else if (shift) crc_q <= {crc_q[14:0], 1'b0};
   end

   assign msb = crc_q[15];
endmodule

// File: rtl/sd_mbw_serial.sv
module sd_mbw_serial (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       shift,
   input  logic       wide,
   input  logic [7:0] din,
   output logic [3:0] lane_bits
);
   logic [7:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= 8'h00;
      else if (load)  sh_q <= din;
      else if (shift) sh_q <= wide ? {sh_q[3:0], 4'h0} : {sh_q[6:0], 1'b0};
   end

   assign lane_bits = wide ? sh_q[7:4] : {3'b000, sh_q[7]};
endmodule

// File: rtl/sd_mbw_resp.sv
module sd_mbw_resp
   import sd_mbw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic dat0_i,
   output logic resp_ok,
   output logic resp_bad,
   output logic card_busy
);
   rsp_state_t rs_q;
   logic [1:0] cnt_q;
   logic [1:0] tok_q;
   logic       tok_last;
   logic       tok_good;

   assign tok_last = (rs_q == R_TOK) && (cnt_q == 2'd2);
   assign tok_good = ({tok_q, dat0_i} == 3'b010);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_q  <= R_IDLE;
         cnt_q <= 2'd0;
         tok_q <= 2'b00;
      end else begin
         case (rs_q)
            R_IDLE:   if (arm) rs_q <= R_WAITSB;
            R_WAITSB: if (!dat0_i) begin
                         rs_q  <= R_TOK;
                         cnt_q <= 2'd0;
                      end
            R_TOK: begin
               tok_q <= {tok_q[0], dat0_i};
               cnt_q <= cnt_q + 2'd1;
               if (tok_last) rs_q <= tok_good ? R_TEND : R_IDLE;
            end
            R_TEND:   rs_q <= R_BUSY;
            R_BUSY:   if (dat0_i) rs_q <= R_IDLE;
            default:  rs_q <= R_IDLE;
         endcase
      end
   end

   assign resp_ok   = (rs_q == R_BUSY) && dat0_i;
   assign resp_bad  = tok_last && !tok_good;
   assign card_busy = (rs_q == R_BUSY);

   assert_tok_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_q == R_TOK) |-> (cnt_q <= 2'd2));
   assert_busy_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rs_q == R_BUSY) && !dat0_i) |=> (rs_q == R_BUSY));
endmodule

// File: rtl/sd_mbw_engine.sv
module sd_mbw_engine
   import sd_mbw_pkg::*;
#(
   parameter int unsigned BLOCK_BYTES = 512,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide,
   input  logic [CNT_W-1:0]  blk_count,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic [3:0]        dat_o,
   output logic [3:0]        dat_oe,
   input  logic              dat0_i,
   output logic              done,
   output logic              err
);
   localparam int unsigned IDX_W = $clog2(BLOCK_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

   if (BLOCK_BYTES < 2 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for one block");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   wr_state_t         st_q;
   logic              wide_q;
   logic [CNT_W-1:0]  blk_left_q;
   logic [IDX_W-1:0]  byte_idx_q;
   logic [2:0]        slot_q;
   logic [3:0]        crc_cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic              err_q;

   logic [2:0] slot_last;
   logic [2:0] slot_pre;
   logic       more_bytes;
   logic       load_byte;
   logic       shift_byte;
   logic [3:0] lane_bits;
   logic [3:0] crc_msb;
   logic [3:0] lane_mask;
   logic [3:0] dat_mux;
   logic       driving;
   logic       resp_ok;
   logic       resp_bad;
   logic       card_busy;

   assign slot_last  = wide_q ? 3'd1 : 3'd7;
   assign slot_pre   = wide_q ? 3'd0 : 3'd6;
   assign more_bytes = (byte_idx_q != LAST_IDX);
   assign rd_req     = (st_q == S_PREP) ||
                       ((st_q == S_DATA) && (slot_q == slot_pre) && more_bytes);
   assign load_byte  = (st_q == S_START) ||
                       ((st_q == S_DATA) && (slot_q == slot_last) && more_bytes);
   assign shift_byte = (st_q == S_DATA);

   sd_mbw_serial u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_byte),
      .shift    (shift_byte),
      .wide     (wide_q),
      .din      (rd_data),
      .lane_bits(lane_bits)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sd_mbw_crc_lane u_crc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (st_q == S_PREP),
         .upd  (st_q == S_DATA),
         .bit_i(lane_bits[l]),
         .shift(st_q == S_CRC),
         .msb  (crc_msb[l])
      );
   end

   sd_mbw_resp u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (st_q == S_ENDB),
      .dat0_i   (dat0_i),
      .resp_ok  (resp_ok),
      .resp_bad (resp_bad),
      .card_busy(card_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         wide_q     <= 1'b0;
         blk_left_q <= '0;
         byte_idx_q <= '0;
         slot_q     <= 3'd0;
         crc_cnt_q  <= 4'd0;
         addr_q     <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         if (rd_req) addr_q <= addr_q + ADDR_W'(1);
         case (st_q)
            S_IDLE: if (start && (blk_count != '0)) begin
               wide_q     <= wide;
               blk_left_q <= blk_count;
               addr_q     <= '0;
               done_q     <= 1'b0;
               err_q      <= 1'b0;
               st_q       <= S_PREP;
            end
            S_PREP: begin
               byte_idx_q <= '0;
               slot_q     <= 3'd0;
               st_q       <= S_START;
            end
            S_START: st_q <= S_DATA;
            S_DATA: begin
               if (slot_q == slot_last) begin
                  slot_q <= 3'd0;
                  if (more_bytes) begin
                     byte_idx_q <= byte_idx_q + IDX_W'(1);
                  end else begin
                     crc_cnt_q <= 4'd0;
                     st_q      <= S_CRC;
                  end
               end else begin
                  slot_q <= slot_q + 3'd1;
               end
            end
            S_CRC: begin
               crc_cnt_q <= crc_cnt_q + 4'd1;
               if (crc_cnt_q == 4'd15) st_q <= S_ENDB;
            end
            S_ENDB: st_q <= S_RESP;
            S_RESP: begin
               if (resp_bad) begin
                  err_q <= 1'b1;
                  st_q  <= S_IDLE;
               end else if (resp_ok) begin
                  if (blk_left_q == CNT_W'(1)) begin
                     done_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else begin
                     blk_left_q <= blk_left_q - CNT_W'(1);
                     st_q       <= S_PREP;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign lane_mask = wide_q ? 4'hF : 4'h1;
   assign driving   = (st_q == S_START) || (st_q == S_DATA) ||
                      (st_q == S_CRC)   || (st_q == S_ENDB);

   always_comb begin
      case (st_q)
         S_START: dat_mux = 4'h0;
         S_DATA:  dat_mux = lane_bits;
         S_CRC:   dat_mux = crc_msb;
         default: dat_mux = 4'hF;
      endcase
   end

   assign dat_o   = dat_mux;
   assign dat_oe  = driving ? lane_mask : 4'h0;
   assign rd_addr = addr_q;
   assign done    = done_q;
   assign err     = err_q;

   assert_narrow_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_q |-> (dat_oe[3:1] == 3'b000));
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_oe[0]) |-> (dat_o[0] == 1'b0));
   assert_end_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_oe[0]) |-> $past(dat_o[0]));
   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_bad |=> (err && (dat_oe == 4'h0)));
   assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (card_busy && !dat0_i) |=> (dat_oe == 4'h0));
   assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
endmodule

// File: tb/sim_sd_mbw_engine.sv
module sim_sd_mbw_engine;
   localparam int CLK_NS = 10;
   localparam int BLK    = 512;
   localparam int WD_CYC = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        wide = 1'b0;
   logic [15:0] blk_count = 16'd0;
   logic        rd_req;
   logic [23:0] rd_addr;
   logic [7:0]  rd_data = 8'h00;
   logic [3:0]  dat_o;
   logic [3:0]  dat_oe;
   logic        card_d = 1'b1;
   logic        done;
   logic        err;

   int checks = 0;
   int errors = 0;
   int eaddr  = 0;
   bit finished = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   sd_mbw_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .blk_count(blk_count),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .dat_o(dat_o), .dat_oe(dat_oe), .dat0_i(card_d), .done(done), .err(err)
   );

   function automatic logic [7:0] memf(input int a);
      return 8'((a * 37) + (a >>> 3) + 90);
   endfunction

   function automatic logic [15:0] crcf(input logic [15:0] c, input logic b);
      logic f;
      f = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
   endfunction

   always @(posedge clk) if (rd_req) rd_data <= memf(int'(rd_addr));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic run_xfer(input logic w, input int nblk, input int busy_len,
                           input logic [2:0] tok, input int bad_blk);
      logic [3:0]  mask;
      int          nd;
      logic [15:0] bc [4];
      logic [15:0] rc [4];
      logic [7:0]  cur;
      int          bad, gap, crcbad, wt;
      longint      bact, bexp;
      logic [2:0]  t;
      mask = w ? 4'hF : 4'h1;
      nd = w ? BLK * 2 : BLK * 8;
      eaddr = 0;
      cur = 8'h00;
      @(negedge clk); start = 1'b1; wide = w; blk_count = 16'(nblk);
      @(negedge clk); start = 1'b0;
      check(done == 1'b0 && err == 1'b0, "R10 flags cleared on new transfer", {done, err}, 0);
      for (int b = 0; b < nblk; b++) begin
         wt = 0;
         while (!dat_oe[0] && wt < 100) begin @(negedge clk); wt++; end
         check(dat_oe == mask && (dat_o & mask) == 4'h0, "R2 start bit",
               {dat_oe, dat_o}, {mask, 4'h0});
         for (int l = 0; l < 4; l++) begin bc[l] = 16'h0; rc[l] = 16'h0; end
         bad = 0; gap = 0; crcbad = 0; bact = 0; bexp = 0;
         for (int i = 0; i < nd; i++) begin
            @(negedge clk);
            if (dat_oe != mask) gap++;
            if (w) begin
               cur = {cur[3:0], dat_o};
               for (int l = 0; l < 4; l++) bc[l] = crcf(bc[l], dat_o[l]);
            end else begin
               cur = {cur[6:0], dat_o[0]};
               bc[0] = crcf(bc[0], dat_o[0]);
            end
            if ((w && (i % 2 == 1)) || (!w && (i % 8 == 7))) begin
               if (cur != memf(eaddr)) begin
                  if (bad == 0) begin bact = cur; bexp = memf(eaddr); end
                  bad++;
               end
               eaddr++;
            end
         end
         for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (dat_oe != mask) gap++;
            for (int l = 0; l < 4; l++) rc[l] = {rc[l][14:0], dat_o[l]};
         end
         for (int l = 0; l < (w ? 4 : 1); l++) if (rc[l] != bc[l]) crcbad++;
         @(negedge clk);
         check(dat_oe == mask && (dat_o & mask) == mask, "R5 end bit high",
               {dat_oe, dat_o}, {mask, mask});
         check(gap == 0, "R3 no gap inside block", gap, 0);
         check(bad == 0, "R2 R6 payload bytes in order", bact, bexp);
         check(crcbad == 0, "R4 per-line CRC16", rc[0], bc[0]);
         @(negedge clk);
         check(dat_oe == 4'h0, "R5 lines released after end bit", dat_oe, 0);
         card_d = 1'b1;
         @(negedge clk); card_d = 1'b0;
         t = (b == bad_blk) ? tok : 3'b010;
         for (int k = 2; k >= 0; k--) begin @(negedge clk); card_d = t[k]; end
         @(negedge clk); card_d = 1'b1;
         if (b == bad_blk) begin
            check(err == 1'b1 && done == 1'b0, "R7 bad token sets err", {done, err}, 1);
            gap = 0;
            for (int i = 0; i < 40; i++) begin
               @(negedge clk);
               if (dat_oe != 4'h0 || rd_req) gap++;
            end
            check(gap == 0, "R7 no block after rejection", gap, 0);
            return;
         end
         gap = 0;
         for (int i = 0; i < busy_len; i++) begin
            @(negedge clk); card_d = 1'b0;
            if (dat_oe != 4'h0) gap++;
         end
         @(negedge clk);
         check(gap == 0, "R8 lines idle while card busy", gap, 0);
         if (b == nblk - 1)
            check(done == 1'b0, "R9 done not before busy ends", done, 0);
         card_d = 1'b1;
      end
      @(negedge clk);
      check(done == 1'b1 && err == 1'b0, "R9 done after last busy", {done, err}, 2);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R9 watchdog expired act=%0d exp=%0d", WD_CYC, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && err == 1'b0 && dat_oe == 4'h0 && rd_req == 1'b0,
            "R1 idle after reset", {done, err, dat_oe, rd_req}, 0);
      // R2 R9 narrow mode sweep over block counts
      for (int n = 1; n <= 3; n++) run_xfer(1'b0, n, 5, 3'b010, -1);
      // R2 R9 wide mode sweep over block counts and short busy lengths
      for (int n = 1; n <= 3; n++) run_xfer(1'b1, n, n - 1, 3'b010, -1);
      // R1 zero block count is ignored
      @(negedge clk); start = 1'b1; blk_count = 16'd0; wide = 1'b1;
      @(negedge clk); start = 1'b0;
      q = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (dat_oe != 4'h0 || rd_req) q++;
      end
      check(q == 0 && done == 1'b1 && err == 1'b0, "R1 zero count ignored",
            {q[7:0], done, err}, 2);
      // R7 all eight token values on a single wide block
      for (int tv = 0; tv < 8; tv++)
         run_xfer(1'b1, 1, 3, 3'(tv), (tv == 2) ? -1 : 0);
      // R7 rejection in the middle of a transfer
      run_xfer(1'b1, 2, 2, 3'b011, 1);
      // R8 long busy period between blocks
      run_xfer(1'b1, 2, 20000, 3'b010, -1);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule